// File: doc/BRIEF.md
# Vector Averaging and Saturating Arithmetic Unit

This block processes two 1024-bit vector operands as packed lanes of 8, 16 or 32 bits and applies one operation to every lane pair in parallel. The operations are saturating addition and subtraction, and a group of halving operations: the mean of the two lanes, the mean with rounding, the halved difference, the halved difference with rounding, and a rounded halved difference that is clamped to the lane range. A select input chooses signed or unsigned lanes. Each lane is first widened to twice its width, by sign or zero extension, and the result is computed at that width before it is narrowed. This means intermediate sums and differences never wrap.

An eighth operation adds the lanes with a one-bit carry-in and wraps the result. A carry vector reports, for every 32-bit word of the operands, the carry out of the 33-bit sum of the two words plus the carry-in. The result, the carry vector and a valid strobe are registered, one cycle after an input marked valid.

Top module: `vec_avgsat_unit`

## Requirements
- R1: `ew_i` selects the lane width: 0 gives 8 bits (128 lanes), 1 gives 16 bits (64 lanes), and 2 or 3 give 32 bits (32 lanes). Lane k occupies bits [k*W +: W] of the operands and of the result.
- R2: `op_i` 0 is saturating add and 1 is saturating subtract. The widened sum or difference is clamped to [-2^(W-1), 2^(W-1)-1] when `sgn_i` is 1 and to [0, 2^W-1] when `sgn_i` is 0.
- R3: `op_i` 2 returns (a+b)>>1 of the widened lanes, rounding toward minus infinity.
- R4: `op_i` 3 returns (a+b+1)>>1 of the widened lanes.
- R5: `op_i` 4 returns the low W bits of (a-b)>>1, where the shift of the signed double-width difference is arithmetic.
- R6: `op_i` 5 returns the low W bits of (a-b+1)>>1, with an arithmetic shift.
- R7: `op_i` 6 returns (a-b+1)>>1 clamped to the lane range given in R2. An unsigned negative value gives 0.
- R8: `op_i` 7 returns the low W bits of a+b+`cin_i` in every lane. For every word j, `carry_o[j]` is bit 32 of the zero-extended sum a[32j+:32] + b[32j+:32] + `cin_i`, whatever the op and width.
- R9: A cycle with `valid_i` high updates `res_o` and `carry_o` at the next clock edge and raises `valid_o` for one cycle. With `valid_i` low, `valid_o` falls and `res_o`/`carry_o` hold.
- R10: During and just after reset, `res_o`, `carry_o` and `valid_o` are all zero.
- R11: Values 8 to 15 of `op_i` give an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands and controls are valid |
| op_i | input | 4 | Operation code |
| sgn_i | input | 1 | 1 for signed lanes, 0 for unsigned lanes |
| ew_i | input | 2 | Lane width select |
| cin_i | input | 1 | Carry-in for op 7 and for the carry vector |
| a_i | input | 1024 | First operand |
| b_i | input | 1024 | Second operand |
| res_o | output | 1024 | Registered result vector |
| carry_o | output | 32 | Registered carry out of each 32-bit word |
| valid_o | output | 1 | Result is valid |

## Verification
The hardest cases to reach are the lane extremes. Saturation boundaries and sign crossings only show up when the lanes hold values such as 0x80, 0x7F, 0xFF and 0x00, and these must appear in the same lane of both operands. Uniform random words rarely produce them. The stimulus therefore builds each operand byte by byte, drawing some bytes from a small set of corner values and the rest at random. Every 16- and 32-bit lane then sees its own mix of extremes. Each op is swept across all widths and both signedness settings with these vectors, and idle cycles are interleaved to show that the outputs hold.

// File: rtl/vas_pkg.sv
package vas_pkg;
  typedef enum logic [3:0] {
    OP_ADDSAT  = 4'd0,
    OP_SUBSAT  = 4'd1,
    OP_AVG     = 4'd2,
    OP_AVGR    = 4'd3,
    OP_NAVG    = 4'd4,
    OP_NAVGR   = 4'd5,
    OP_NAVGRS  = 4'd6,
    OP_ADDC    = 4'd7,
    OP_RSV8    = 4'd8,
    OP_RSV9    = 4'd9,
    OP_RSV10   = 4'd10,
    OP_RSV11   = 4'd11,
    OP_RSV12   = 4'd12,
    OP_RSV13   = 4'd13,
    OP_RSV14   = 4'd14,
    OP_RSV15   = 4'd15
  } vas_op_e;

  localparam int unsigned NUM_EW = 3;
endpackage

// File: rtl/vas_elem.sv
module vas_elem
  import vas_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  vas_op_e      op_i,
  input  logic         sgn_i,
  input  logic         cin_i,
  output logic [W-1:0] res_o
);
  localparam int unsigned DW = 2 * W;

  logic signed [DW-1:0] ax, bx, sum, dif, sum_r, dif_r;
  logic signed [DW-1:0] hi, lo, addc, pick;
  logic                 do_sat;

  assign ax    = sgn_i ? {{W{a_i[W-1]}}, a_i} : {{W{1'b0}}, a_i};
  assign bx    = sgn_i ? {{W{b_i[W-1]}}, b_i} : {{W{1'b0}}, b_i};
  assign sum   = ax + bx;
  assign dif   = ax - bx;
  assign sum_r = sum + {{(DW-1){1'b0}}, 1'b1};
  assign dif_r = dif + {{(DW-1){1'b0}}, 1'b1};
  assign addc  = sum + {{(DW-1){1'b0}}, cin_i};

  assign hi = sgn_i ? {{(W+1){1'b0}}, {(W-1){1'b1}}} : {{W{1'b0}}, {W{1'b1}}};
  assign lo = sgn_i ? {{(W+1){1'b1}}, {(W-1){1'b0}}} : '0;

  always_comb begin
    do_sat = 1'b0;
    pick   = '0;
    unique case (op_i)
      OP_ADDSAT: begin pick = sum;        do_sat = 1'b1; end
      OP_SUBSAT: begin pick = dif;        do_sat = 1'b1; end
      OP_AVG:          pick = sum >>> 1;
      OP_AVGR:         pick = sum_r >>> 1;
      OP_NAVG:         pick = dif >>> 1;
      OP_NAVGR:        pick = dif_r >>> 1;
      OP_NAVGRS: begin pick = dif_r >>> 1; do_sat = 1'b1; end
      OP_ADDC:         pick = addc;
      default:         pick = '0;
    endcase
  end

  always_comb begin
    if (do_sat && (pick > hi))      res_o = hi[W-1:0];
    else if (do_sat && (pick < lo)) res_o = lo[W-1:0];
    else                            res_o = pick[W-1:0];
  end
endmodule

// File: rtl/vas_carry.sv
module vas_carry #(
  parameter int unsigned VEC_W = 1024
) (
  input  logic [VEC_W-1:0]    a_i,
  input  logic [VEC_W-1:0]    b_i,
  input  logic                cin_i,
  output logic [VEC_W/32-1:0] carry_o
);
  localparam int unsigned NW = VEC_W / 32;

  for (genvar j = 0; j < NW; j++) begin : gen_word
    logic [32:0] s33;
    assign s33        = {1'b0, a_i[j*32 +: 32]} + {1'b0, b_i[j*32 +: 32]} + {32'd0, cin_i};
    assign carry_o[j] = s33[32];
  end
endmodule

// File: rtl/vec_avgsat_unit.sv
module vec_avgsat_unit
  import vas_pkg::*;
#(
  parameter int unsigned VEC_W = 1024
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [3:0]          op_i,
  input  logic                sgn_i,
  input  logic [1:0]          ew_i,
  input  logic                cin_i,
  input  logic [VEC_W-1:0]    a_i,
  input  logic [VEC_W-1:0]    b_i,
  output logic [VEC_W-1:0]    res_o,
  output logic [VEC_W/32-1:0] carry_o,
  output logic                valid_o
);
  localparam int unsigned NW = VEC_W / 32;

  vas_op_e          op;
  logic [VEC_W-1:0] res_d;
  logic [NW-1:0]    carry_d;

  assign op = vas_op_e'(op_i);

  for (genvar g = 0; g < NUM_EW; g++) begin : gen_w
    localparam int unsigned W  = 8 << g;
    localparam int unsigned NL = VEC_W / W;
    logic [VEC_W-1:0] part;
    for (genvar l = 0; l < NL; l++) begin : gen_lane
      vas_elem #(.W(W)) u_elem (
        .a_i   (a_i[l*W +: W]),
        .b_i   (b_i[l*W +: W]),
        .op_i  (op),
        .sgn_i (sgn_i),
        .cin_i (cin_i),
        .res_o (part[l*W +: W])
      );
    end
  end

  always_comb begin
    unique case (ew_i)
      2'd0:    res_d = gen_w[0].part;
      2'd1:    res_d = gen_w[1].part;
      default: res_d = gen_w[2].part;
    endcase
  end

  vas_carry #(.VEC_W(VEC_W)) u_carry (
    .a_i     (a_i),
    .b_i     (b_i),
    .cin_i   (cin_i),
    .carry_o (carry_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o   <= '0;
      carry_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        res_o   <= res_d;
        carry_o <= carry_d;
      end
    end
  end

  p_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(res_o) && $stable(carry_o)));

  p_uaddsat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd0 && !sgn_i && ew_i == 2'd0)
      |=> (res_o[7:0] >= $past(a_i[7:0])));

  p_usubsat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd1 && !sgn_i && ew_i == 2'd0)
      |=> (res_o[7:0] <= $past(a_i[7:0])));

  p_carry_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cin_i && a_i[31:0] == 32'hFFFF_FFFF) |=> carry_o[0]);

  p_rsv_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i[3]) |=> (res_o == '0));
endmodule

// File: tb/sim_vec_avgsat_unit.sv
module sim_vec_avgsat_unit;
  localparam int VW = 1024;
  localparam int NW = VW / 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid = 1'b0;
  logic [3:0]    op = '0;
  logic          sgn = 1'b0;
  logic [1:0]    ew = '0;
  logic          cin = 1'b0;
  logic [VW-1:0] a = '0, b = '0;
  logic [VW-1:0] res;
  logic [NW-1:0] carry;
  logic          vout;

  int checks = 0, failures = 0;
  logic [VW-1:0] exp_res = '0;
  logic [NW-1:0] exp_carry = '0;
  logic          exp_valid = 1'b0;
  string         exp_tag = "R10";

  always #2 clk = ~clk;

  vec_avgsat_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .sgn_i(sgn),
    .ew_i(ew), .cin_i(cin), .a_i(a), .b_i(b), .res_o(res), .carry_o(carry),
    .valid_o(vout)
  );

  function automatic longint ref_elem(int o, bit s, int w, longint ua, longint ub, bit c);
    longint ax, bx, v, hi, lo, m;
    bit sat;
    m  = (longint'(1) << w) - 1;
    ax = (s && ua[w-1]) ? ua - (longint'(1) << w) : ua;
    bx = (s && ub[w-1]) ? ub - (longint'(1) << w) : ub;
    hi = s ? (longint'(1) << (w-1)) - 1 : m;
    lo = s ? -(longint'(1) << (w-1)) : 0;
    sat = 0;
    case (o)
      0: begin v = ax + bx; sat = 1; end
      1: begin v = ax - bx; sat = 1; end
      2: v = (ax + bx) >>> 1;
      3: v = (ax + bx + 1) >>> 1;
      4: v = (ax - bx) >>> 1;
      5: v = (ax - bx + 1) >>> 1;
      6: begin v = (ax - bx + 1) >>> 1; sat = 1; end
      7: v = ax + bx + longint'(c);
      default: v = 0;
    endcase
    if (sat && v > hi) v = hi;
    if (sat && v < lo) v = lo;
    return v & m;
  endfunction

  function automatic string tag_of(int o, int e);
    case (o)
      0, 1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      6: return "R7";
      7: return "R8";
      default: return (e == 3) ? "R1" : "R11";
    endcase
  endfunction

  task automatic check_now();
    checks++;
    if (vout !== exp_valid || res !== exp_res || carry !== exp_carry) begin
      failures++;
      $display("FAIL %s valid=%0b/%0b carry=%h/%h res=%h exp=%h", exp_tag,
               vout, exp_valid, carry, exp_carry, res, exp_res);
    end
  endtask

  task automatic step(bit v, int o, bit s, int e, logic [VW-1:0] va, logic [VW-1:0] vb, bit c);
    int w;
    @(negedge clk);
    check_now();
    valid = v; op = 4'(o); sgn = s; ew = 2'(e); a = va; b = vb; cin = c;
    exp_valid = v;
    if (v) begin
      w = (e == 0) ? 8 : (e == 1) ? 16 : 32;
      for (int i = 0; i < VW / w; i++) begin
        longint ua, ub, r;
        ua = longint'(64'(va >> (i*w))) & ((longint'(1) << w) - 1);
        ub = longint'(64'(vb >> (i*w))) & ((longint'(1) << w) - 1);
        r  = ref_elem(o, s, w, ua, ub, c);
        for (int k = 0; k < w; k++) exp_res[i*w + k] = r[k];
      end
      for (int j = 0; j < NW; j++) begin
        longint sw;
        sw = longint'(va[j*32 +: 32]) + longint'(vb[j*32 +: 32]) + longint'(c);
        exp_carry[j] = sw[32];
      end
      exp_tag = tag_of(o, e);
    end else begin
      exp_tag = "R9";
    end
  endtask

  function automatic logic [VW-1:0] corner_vec();
    logic [VW-1:0] r;
    logic [7:0] cs [6] = '{8'h00, 8'h7F, 8'h80, 8'hFF, 8'h01, 8'hFE};
    for (int i = 0; i < VW / 8; i++)
      r[i*8 +: 8] = ($urandom_range(0, 1) == 0) ? cs[$urandom_range(0, 5)] : 8'($urandom);
    return r;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog timeout");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [VW-1:0] ones;
    ones = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    check_now();
    rst_n = 1'b1;
    step(0, 0, 0, 0, '0, '0, 0);
    // R8: carry ripple from all-ones plus carry-in
    step(1, 7, 0, 2, ones, '0, 1);
    step(1, 7, 1, 0, ones, '0, 0);
    // R1: width 3 behaves as 32
    step(1, 2, 1, 3, corner_vec(), corner_vec(), 0);
    for (int o = 0; o < 8; o++)
      for (int s = 0; s < 2; s++)
        for (int e = 0; e < 3; e++)
          for (int p = 0; p < 4; p++) begin
            step(1, o, s[0], e, corner_vec(), corner_vec(), p[0]);
            if (p == 2) step(0, 3, 1, 1, corner_vec(), corner_vec(), 1); // R9 hold
          end
    // R11: reserved opcodes
    for (int o = 8; o < 16; o++) step(1, o, o[0], o % 3, corner_vec(), corner_vec(), 1);
    step(0, 0, 0, 0, '0, '0, 0);
    step(0, 0, 0, 0, '0, '0, 0);
    @(negedge clk);
    check_now();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule